// File: doc/BRIEF.md
# Trap Routing and Privilege Return Unit

This block decides, each cycle, whether a hart with machine, supervisor and user privilege levels must leave its normal instruction flow. Its inputs are one synchronous exception request with a cause code, a vector of pending interrupt lines, the PC of the faulting or interrupted instruction, and requests to return from a machine-level or supervisor-level handler. When a redirect is needed, it raises a valid flag for that cycle and presents the target PC. On the next clock edge it commits the new privilege level and updates the trap-related control registers.

Global interrupt-enable bits gate asynchronous interrupts only. A synchronous exception always traps, including when it is raised inside a handler with every enable bit cleared. Delegation to supervisor level is decided per cause, through an exception-delegation mask and an interrupt-delegation mask. A trap is never delegated below the current privilege level.

The control registers are written and read through a small selector-addressed port. Decode, pipelining and vectored handler dispatch belong to the surrounding core.

Top module: `trap_router`

## Requirements
- R1: A valid exception produces a redirect in the same cycle, whatever the machine and supervisor interrupt-enable bits hold. Interrupt-enable bits never mask exceptions.
- R2: An interrupt whose handling level is machine is taken from supervisor or user level unconditionally. From machine level it is taken only when status bit 3 (machine interrupt enable) is 1.
- R3: An interrupt whose handling level is supervisor is taken from user level unconditionally. From supervisor level it is taken only when status bit 1 (supervisor interrupt enable) is 1.
- R4: An exception is handled at supervisor level when the exception-delegation bit indexed by its cause is 1 and the current level is below machine. Otherwise it is handled at machine level.
- R5: An interrupt on line i is handled at supervisor level when interrupt-delegation bit i is 1 and the current level is below machine. Otherwise it is handled at machine level.
- R6: No trap raised at machine level is delegated. It is handled at machine level even when its delegation bit is set.
- R7: The redirect PC of a trap is the handling level's vector register with bits 1:0 forced to 0.
- R8: On trap entry, the handling level's EPC takes the trap PC. Its cause register takes the code, with the MSB set for interrupts. Its previous-enable bit takes its enable bit, and its enable bit clears. Its previous-privilege field takes the old level: bits 12:11 for machine, bit 8 for supervisor. privOut becomes the handling level (encodings: U=0, S=1, M=3).
- R9: An exception raised while already in a machine handler with all enables 0 traps again to the machine vector and overwrites the saved PC and cause.
- R10: An exception wins over pending interrupts in the same cycle. Among takeable interrupts, the lowest line index wins.
- R11: A machine return redirects to the machine EPC and sets privOut to bits 12:11. Bit 3 takes bit 7, bit 7 becomes 1, and bits 12:11 become 0.
- R12: A supervisor return redirects to the supervisor EPC and sets privOut to {0, bit 8}. Bit 1 takes bit 5, bit 5 becomes 1, and bit 8 becomes 0.
- R13: After reset, privOut is M, the status word and the other registers are 0, and no redirect is raised.
- R14: Register selectors are 0 status, 1 exception delegation, 2 interrupt delegation, 3 machine vector, 4 supervisor vector, 5 machine EPC, 6 supervisor EPC, 7 machine cause, 8 supervisor cause. Only status bits 1, 3, 5, 7, 8, 12:11 are stored. A trap or return in the same cycle takes precedence over a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | Synchronous exception request |
| excCause | input | 5 | Exception cause code |
| irqPending | input | NIRQ | Pending interrupt lines |
| pc | input | XLEN | PC of the trapping instruction |
| mretReq | input | 1 | Machine-level return request |
| sretReq | input | 1 | Supervisor-level return request |
| csrWe | input | 1 | Register write strobe |
| csrAddr | input | 4 | Register selector |
| csrWdata | input | XLEN | Register write data |
| csrRdata | output | XLEN | Register read data for csrAddr |
| redirValid | output | 1 | Redirect this cycle |
| redirPc | output | XLEN | Redirect target |
| privOut | output | 2 | Current privilege level |

## Verification
The main function is driven with exceptions from all three levels, with and without delegation bits set, and with nested exceptions inside a machine handler where all enables are clear. These runs separate the routing decision from the masking decision. Interrupt patterns cover masked and unmasked cases, delegated and non-delegated lines, and several lines pending together. Together they show whether the enable check uses the handling level rather than the current level, and whether the lowest line index wins. Exceptions and interrupts raised in the same cycle test the priority order. Chains of machine and supervisor returns show whether the saved privilege and enable bits unwind correctly.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CAUSE_W = 5;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;

  localparam logic [3:0] SEL_STATUS = 4'd0;
  localparam logic [3:0] SEL_EDELEG = 4'd1;
  localparam logic [3:0] SEL_IDELEG = 4'd2;
  localparam logic [3:0] SEL_MTVEC  = 4'd3;
  localparam logic [3:0] SEL_STVEC  = 4'd4;
  localparam logic [3:0] SEL_MEPC   = 4'd5;
  localparam logic [3:0] SEL_SEPC   = 4'd6;
  localparam logic [3:0] SEL_MCAUSE = 4'd7;
  localparam logic [3:0] SEL_SCAUSE = 4'd8;

  typedef struct packed {
    logic               enterM;
    logic               enterS;
    logic               doMret;
    logic               doSret;
    logic               isIrq;
    logic [CAUSE_W-1:0] code;
  } trapStb_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NIRQ = 16
) (
  input  logic               excValid,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [NIRQ-1:0]    irqPending,
  input  logic               mretReq,
  input  logic               sretReq,
  input  logic [1:0]         priv,
  input  logic               mie,
  input  logic               sie,
  input  logic [XLEN-1:0]    medeleg,
  input  logic [NIRQ-1:0]    mideleg,
  output trapStb_t           stb,
  output logic               redirValid
);
  logic [NIRQ-1:0] irqToS;
  logic [NIRQ-1:0] irqOk;
  logic            belowM;

  assign belowM = (priv != PRIV_M);

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    assign irqToS[i] = mideleg[i] && belowM;
    assign irqOk[i]  = irqPending[i] &&
                       (irqToS[i] ? ((priv == PRIV_U) || (priv == PRIV_S && sie))
                                  : (belowM || mie));
  end

  logic               anyIrq;
  logic [CAUSE_W-1:0] irqIdx;
  logic               irqSelS;

  always_comb begin
    anyIrq  = 1'b0;
    irqIdx  = '0;
    irqSelS = 1'b0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (irqOk[i]) begin
        anyIrq  = 1'b1;
        irqIdx  = CAUSE_W'(i);
        irqSelS = irqToS[i];
      end
    end
  end

  logic excToS;
  assign excToS = medeleg[excCause] && belowM;

  always_comb begin
    stb = '0;
    if (excValid) begin
      stb.code   = excCause;
      stb.enterS = excToS;
      stb.enterM = !excToS;
    end else if (anyIrq) begin
      stb.isIrq  = 1'b1;
      stb.code   = irqIdx;
      stb.enterS = irqSelS;
      stb.enterM = !irqSelS;
    end else if (mretReq) begin
      stb.doMret = 1'b1;
    end else if (sretReq) begin
      stb.doSret = 1'b1;
    end
  end

  assign redirValid = stb.enterM | stb.enterS | stb.doMret | stb.doSret;
endmodule

// File: rtl/trap_csr.sv
module trap_csr
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NIRQ = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  trapStb_t        stb,
  input  logic [XLEN-1:0] pc,
  input  logic            csrWe,
  input  logic [3:0]      csrAddr,
  input  logic [XLEN-1:0] csrWdata,
  output logic [XLEN-1:0] csrRdata,
  output logic [XLEN-1:0] redirPc,
  output logic [1:0]      priv,
  output logic [XLEN-1:0] status,
  output logic [XLEN-1:0] medeleg,
  output logic [NIRQ-1:0] mideleg
);
  localparam int PAD_W = XLEN - 1 - CAUSE_W;
  localparam logic [XLEN-1:0] ST_KEEP = XLEN'((1 << ST_SIE) | (1 << ST_MIE) |
      (1 << ST_SPIE) | (1 << ST_MPIE) | (1 << ST_SPP) | (3 << ST_MPP));

  logic [XLEN-1:0] mtvec, stvec, mepc, sepc, mcause, scause;
  logic [XLEN-1:0] causeVal;

  assign causeVal = {stb.isIrq, {PAD_W{1'b0}}, stb.code};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priv    <= PRIV_M;
      status  <= '0;
      medeleg <= '0;
      mideleg <= '0;
      mtvec   <= '0;
      stvec   <= '0;
      mepc    <= '0;
      sepc    <= '0;
      mcause  <= '0;
      scause  <= '0;
    end else if (stb.enterM) begin
      mepc                   <= pc;
      mcause                 <= causeVal;
      status[ST_MPIE]        <= status[ST_MIE];
      status[ST_MIE]         <= 1'b0;
      status[ST_MPP+:2]      <= priv;
      priv                   <= PRIV_M;
    end else if (stb.enterS) begin
      sepc                   <= pc;
      scause                 <= causeVal;
      status[ST_SPIE]        <= status[ST_SIE];
      status[ST_SIE]         <= 1'b0;
      status[ST_SPP]         <= priv[0];
      priv                   <= PRIV_S;
    end else if (stb.doMret) begin
      priv                   <= status[ST_MPP+:2];
      status[ST_MIE]         <= status[ST_MPIE];
      status[ST_MPIE]        <= 1'b1;
      status[ST_MPP+:2]      <= PRIV_U;
    end else if (stb.doSret) begin
      priv                   <= {1'b0, status[ST_SPP]};
      status[ST_SIE]         <= status[ST_SPIE];
      status[ST_SPIE]        <= 1'b1;
      status[ST_SPP]         <= 1'b0;
    end else if (csrWe) begin
      case (csrAddr)
        SEL_STATUS: status  <= csrWdata & ST_KEEP;
        SEL_EDELEG: medeleg <= csrWdata;
        SEL_IDELEG: mideleg <= csrWdata[NIRQ-1:0];
        SEL_MTVEC:  mtvec   <= csrWdata;
        SEL_STVEC:  stvec   <= csrWdata;
        SEL_MEPC:   mepc    <= csrWdata;
        SEL_SEPC:   sepc    <= csrWdata;
        SEL_MCAUSE: mcause  <= csrWdata;
        SEL_SCAUSE: scause  <= csrWdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    redirPc = '0;
    if (stb.enterM)      redirPc = {mtvec[XLEN-1:2], 2'b00};
    else if (stb.enterS) redirPc = {stvec[XLEN-1:2], 2'b00};
    else if (stb.doMret) redirPc = mepc;
    else if (stb.doSret) redirPc = sepc;
  end

  always_comb begin
    case (csrAddr)
      SEL_STATUS: csrRdata = status;
      SEL_EDELEG: csrRdata = medeleg;
      SEL_IDELEG: csrRdata = XLEN'(mideleg);
      SEL_MTVEC:  csrRdata = mtvec;
      SEL_STVEC:  csrRdata = stvec;
      SEL_MEPC:   csrRdata = mepc;
      SEL_SEPC:   csrRdata = sepc;
      SEL_MCAUSE: csrRdata = mcause;
      SEL_SCAUSE: csrRdata = scause;
      default:    csrRdata = '0;
    endcase
  end
endmodule

// File: rtl/trap_router.sv
module trap_router
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NIRQ = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               excValid,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [NIRQ-1:0]    irqPending,
  input  logic [XLEN-1:0]    pc,
  input  logic               mretReq,
  input  logic               sretReq,
  input  logic               csrWe,
  input  logic [3:0]         csrAddr,
  input  logic [XLEN-1:0]    csrWdata,
  output logic [XLEN-1:0]    csrRdata,
  output logic               redirValid,
  output logic [XLEN-1:0]    redirPc,
  output logic [1:0]         privOut
);
  trapStb_t        stb;
  logic [XLEN-1:0] statusQ;
  logic [XLEN-1:0] medelegQ;
  logic [NIRQ-1:0] midelegQ;

  trap_ctrl #(.XLEN(XLEN), .NIRQ(NIRQ)) u_ctrl (
    .excValid  (excValid),
    .excCause  (excCause),
    .irqPending(irqPending),
    .mretReq   (mretReq),
    .sretReq   (sretReq),
    .priv      (privOut),
    .mie       (statusQ[ST_MIE]),
    .sie       (statusQ[ST_SIE]),
    .medeleg   (medelegQ),
    .mideleg   (midelegQ),
    .stb       (stb),
    .redirValid(redirValid)
  );

  trap_csr #(.XLEN(XLEN), .NIRQ(NIRQ)) u_csr (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .pc      (pc),
    .csrWe   (csrWe),
    .csrAddr (csrAddr),
    .csrWdata(csrWdata),
    .csrRdata(csrRdata),
    .redirPc (redirPc),
    .priv    (privOut),
    .status  (statusQ),
    .medeleg (medelegQ),
    .mideleg (midelegQ)
  );
endmodule

// File: rtl/trap_router_chk.sv
module trap_router_chk
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            excValid,
  input logic            mretReq,
  input logic            sretReq,
  input logic            redirValid,
  input logic [XLEN-1:0] redirPc,
  input logic [1:0]      privOut,
  input logic [XLEN-1:0] statusQ,
  input trapStb_t        stb
);
  AST_EXC_NEVER_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> redirValid) else $error("exception not redirected"); // R1

  AST_MIRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (privOut == PRIV_M && !statusQ[ST_MIE] && !excValid && !mretReq && !sretReq)
      |-> !redirValid) else $error("masked interrupt taken"); // R2

  AST_M_STAYS_M: assert property (@(posedge clk) disable iff (!rstN)
    (privOut == PRIV_M && excValid) |=> privOut == PRIV_M)
    else $error("trap delegated below M"); // R6

  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enterM || stb.enterS) |-> redirPc[1:0] == 2'b00)
    else $error("unaligned vector"); // R7

  AST_ENTRY_CLEARS_IE: assert property (@(posedge clk) disable iff (!rstN)
    stb.enterM |=> !statusQ[ST_MIE] && privOut == PRIV_M)
    else $error("entry did not clear enable"); // R8

  AST_MRET_UNWIND: assert property (@(posedge clk) disable iff (!rstN)
    stb.doMret |=> statusQ[ST_MPIE] && statusQ[ST_MPP+:2] == PRIV_U)
    else $error("mret unwind wrong"); // R11
endmodule

bind trap_router trap_router_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .excValid  (excValid),
  .mretReq   (mretReq),
  .sretReq   (sretReq),
  .redirValid(redirValid),
  .redirPc   (redirPc),
  .privOut   (privOut),
  .statusQ   (statusQ),
  .stb       (stb)
);

// File: tb/trap_router_tb.sv
module trap_router_tb;
  localparam int XLEN = 32;
  localparam int NIRQ = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            excValid = 1'b0;
  logic [4:0]      excCause = '0;
  logic [NIRQ-1:0] irqPending = '0;
  logic [XLEN-1:0] pc = '0;
  logic            mretReq = 1'b0;
  logic            sretReq = 1'b0;
  logic            csrWe = 1'b0;
  logic [3:0]      csrAddr = '0;
  logic [XLEN-1:0] csrWdata = '0;
  logic [XLEN-1:0] csrRdata;
  logic            redirValid;
  logic [XLEN-1:0] redirPc;
  logic [1:0]      privOut;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trap_router #(.XLEN(XLEN), .NIRQ(NIRQ)) u_dut (.*);

  typedef struct {
    string           tag;
    logic            v;
    logic [XLEN-1:0] tgt;
    logic [1:0]      pr;
  } exp_t;

  exp_t sbq[$];

  task automatic check(string tag, logic [XLEN-1:0] got, logic [XLEN-1:0] want);
    nRun++;
    if (got !== want) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  task automatic drive(logic e, logic [4:0] c, logic [NIRQ-1:0] irq, logic [XLEN-1:0] p,
                       logic mr, logic sr, logic we, logic [3:0] a, logic [XLEN-1:0] d);
    excValid = e; excCause = c; irqPending = irq; pc = p;
    mretReq = mr; sretReq = sr; csrWe = we; csrAddr = a; csrWdata = d;
  endtask

  task automatic step(string tag, logic e, logic [4:0] c, logic [NIRQ-1:0] irq,
                      logic [XLEN-1:0] p, logic mr, logic sr,
                      logic ev, logic [XLEN-1:0] et, logic [1:0] ep);
    exp_t it;
    @(negedge clk);
    drive(e, c, irq, p, mr, sr, 1'b0, 4'd0, '0);
    it.tag = tag; it.v = ev; it.tgt = et; it.pr = ep;
    sbq.push_back(it);
  endtask

  task automatic wr(logic [3:0] a, logic [XLEN-1:0] d);
    @(negedge clk);
    drive(1'b0, 5'd0, '0, '0, 1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [XLEN-1:0] want);
    @(negedge clk);
    drive(1'b0, 5'd0, '0, '0, 1'b0, 1'b0, 1'b0, a, '0);
    #5;
    check(tag, csrRdata, want);
  endtask

  // monitor: pops expectations, compares redirect before the edge, privilege after it
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sbq.size() != 0) begin
        exp_t it;
        logic gv;
        logic [XLEN-1:0] gt;
        it = sbq.pop_front();
        gv = redirValid;
        gt = redirPc;
        @(posedge clk);
        #2;
        check({it.tag, " redirValid"}, XLEN'(gv), XLEN'(it.v));
        if (it.v) check({it.tag, " redirPc"}, gt, it.tgt);
        check({it.tag, " privOut"}, XLEN'(privOut), XLEN'(it.pr));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R13 reset state
    rd("R13 status", 4'd0, 32'h0);
    check("R13 privOut", XLEN'(privOut), 32'd3);
    check("R13 redirValid", XLEN'(redirValid), 32'd0);
    rd("R13 mepc", 4'd5, 32'h0);

    // R14 setup: vectors with low bits set, delegate cause 8 and line 1
    wr(4'd3, 32'h103);
    wr(4'd4, 32'h203);
    wr(4'd1, 32'h100);
    wr(4'd2, 32'h2);
    rd("R14 medeleg", 4'd1, 32'h100);
    rd("R14 mtvec", 4'd3, 32'h103);

    // R1 R7 exception in M with all enables clear
    step("R1 exc in M", 1'b1, 5'd2, '0, 32'h40, 1'b0, 1'b0, 1'b1, 32'h100, 2'd3);
    rd("R8 mepc", 4'd5, 32'h40);
    rd("R8 mcause", 4'd7, 32'h2);
    rd("R8 status", 4'd0, 32'h1800);

    // R9 R6 nested delegable exception inside M handler
    step("R9 nested exc", 1'b1, 5'd8, '0, 32'h104, 1'b0, 1'b0, 1'b1, 32'h100, 2'd3);
    rd("R9 mepc", 4'd5, 32'h104);
    rd("R6 mcause", 4'd7, 32'h8);

    // R2 masked interrupt in M
    step("R2 masked irq", 1'b0, 5'd0, 16'h0008, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd3);

    // R11 return chain
    step("R11 mret to M", 1'b0, 5'd0, '0, 32'h0, 1'b1, 1'b0, 1'b1, 32'h104, 2'd3);
    rd("R11 status", 4'd0, 32'h80);
    step("R11 mret to U", 1'b0, 5'd0, '0, 32'h0, 1'b1, 1'b0, 1'b1, 32'h104, 2'd0);
    rd("R11 status2", 4'd0, 32'h88);

    // R4 delegated exception from U
    step("R4 exc to S", 1'b1, 5'd8, '0, 32'h300, 1'b0, 1'b0, 1'b1, 32'h200, 2'd1);
    rd("R4 sepc", 4'd6, 32'h300);
    rd("R4 scause", 4'd8, 32'h8);
    rd("R8 status S entry", 4'd0, 32'h88);

    // R4 non-delegated cause from S goes to M
    step("R4 exc S to M", 1'b1, 5'd2, '0, 32'h204, 1'b0, 1'b0, 1'b1, 32'h100, 2'd3);
    rd("R8 status MPP=S", 4'd0, 32'h880);
    step("R11 mret to S", 1'b0, 5'd0, '0, 32'h0, 1'b1, 1'b0, 1'b1, 32'h204, 2'd1);

    // R3 S-target irq masked by SIE=0 in S
    step("R3 masked S irq", 1'b0, 5'd0, 16'h0002, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd1);
    // R2 M-target irq from S taken regardless
    step("R2 irq S to M", 1'b0, 5'd0, 16'h0008, 32'h208, 1'b0, 1'b0, 1'b1, 32'h100, 2'd3);
    rd("R8 irq mcause", 4'd7, 32'h8000_0003);
    rd("R8 irq mepc", 4'd5, 32'h208);

    // R10 exception beats interrupt
    wr(4'd0, 32'h8);
    step("R10 exc vs irq", 1'b1, 5'd5, 16'h0008, 32'h60, 1'b0, 1'b0, 1'b1, 32'h100, 2'd3);
    rd("R10 mcause", 4'd7, 32'h5);
    rd("R10 status", 4'd0, 32'h1880);

    // R10 lowest line wins, R2 enabled irq in M
    wr(4'd0, 32'h8);
    step("R10 irq order", 1'b0, 5'd0, 16'h0088, 32'h70, 1'b0, 1'b0, 1'b1, 32'h100, 2'd3);
    rd("R10 irq cause", 4'd7, 32'h8000_0003);

    // R12 supervisor return
    wr(4'd0, 32'h120);
    wr(4'd6, 32'h500);
    step("R12 sret", 1'b0, 5'd0, '0, 32'h0, 1'b0, 1'b1, 1'b1, 32'h500, 2'd1);
    rd("R12 status", 4'd0, 32'h22);

    // R5 R3 delegated interrupt taken in S with SIE=1
    step("R5 irq to S", 1'b0, 5'd0, 16'h0002, 32'h510, 1'b0, 1'b0, 1'b1, 32'h200, 2'd1);
    rd("R5 scause", 4'd8, 32'h8000_0001);
    rd("R5 sepc", 4'd6, 32'h510);
    rd("R8 status S irq", 4'd0, 32'h120);

    // R14 status field masking
    wr(4'd0, 32'hFFFF_FFFF);
    rd("R14 status mask", 4'd0, 32'h19AA);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule